// File: doc/BRIEF.md
# MMU Control Register File

This block holds the software-visible control state of one side of a memory management unit: the primary and secondary translation contexts, the fault status and fault address, the translation storage buffer (TSB) configuration, the tag-access word captured on a miss, and two watchpoint words. Software reaches it through a single-cycle request port that carries a register number, a write flag and write data. A read answers one cycle later. Some words are computed rather than stored. Register 0 returns a tag-target word built from the tag-access register. Two further outputs give the 8 KB and 64 KB TSB entry pointers, derived from the TSB configuration and the tag-access word.

One parameter selects the data-side or the instruction-side variant. The instruction-side variant keeps no contexts and no watchpoints, because translation on both sides uses the context stored in the data-side copy. The lookup unit reports faults and misses through dedicated update inputs. These updates overwrite the matching registers and win over a software write in the same cycle.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: After synchronous reset every register reads zero, `rsp_valid` is low, and `tsb_ptr_8k`, `tsb_ptr_64k` and `prim_ctx` are zero.
- R2: A read of register 0 returns (tag-access[12:0] << 48) | (tag-access >> 22), where tag-access is register 6.
- R3: Software writes to register 0 (tag target) and register 4 (fault address) have no effect.
- R4: A software write to register 3 (fault status) with data bit 0 at zero sets it to zero, and on the data side it also zeroes register 4. With bit 0 at one, the data is stored as written.
- R5: On the instruction side, writes to registers 1, 2, 7 and 8 are ignored, those registers read zero, and `prim_ctx` stays zero.
- R6: On the data side, registers 1 (primary context), 2 (secondary context), 5 (TSB config), 6 (tag access), 7 and 8 (watchpoints) read back the full 64-bit value last written. `prim_ctx` carries bits 12:0 of register 1. On both sides, registers 5 and 6 read back as written.
- R7: Register numbers 9 to 15 read zero, and writes to them are ignored.
- R8: The TSB config is decoded as follows: base = bits 63:13, split flag = bit 12, size n = bits 3:0. With split clear, a pointer is base (aligned to 2^(13+n)) plus 16 times (VPN mod 512·2^n). VPN is tag-access >> 13 for the 8 KB pointer and tag-access >> 16 for the 64 KB pointer.
- R9: With split set, the base is aligned to 2^(14+n). Bit 13+n of the pointer is 0 for the 8 KB pointer and 1 for the 64 KB pointer. The index field is the same as in R8.
- R10: A fault update loads register 3 from `flt_status` and register 4 from `flt_addr`, and wins over a software write in the same cycle.
- R11: A miss update loads register 6 from `miss_tag`, and wins over a software write in the same cycle.
- R12: Every read request produces exactly one `rsp_valid` pulse, on the cycle after the request. Write requests produce none.
- R13: The pointer outputs are registered and reflect register state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | IDX_W | Register number |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after request) |
| rsp_rdata | output | 64 | Read data |
| flt_valid | input | 1 | Fault update from lookup unit |
| flt_status | input | 64 | Fault status value to load |
| flt_addr | input | 64 | Fault address value to load |
| miss_valid | input | 1 | Miss update from lookup unit |
| miss_tag | input | 64 | Tag-access value to load |
| tsb_ptr_8k | output | 64 | Registered 8 KB TSB pointer |
| tsb_ptr_64k | output | 64 | Registered 64 KB TSB pointer |
| prim_ctx | output | CTX_W | Primary context used for translation |

## Verification
The assertions watch, on every cycle, the things one clock can show. These are the read response timing, the read-only fault address, the fault-status clear, and the priority of fault and miss updates over software writes. On the instruction side they also check that a context write leaves the context unchanged. The scenarios alone show the arithmetic. That covers the tag-target word, the TSB pointers in split and non-split form at different sizes, and the side-dependent clearing of the fault address. The scenarios also show that unmapped register numbers read zero through the normal read path.

// File: rtl/mmu_creg_pkg.sv
package mmu_creg_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned PG_SHIFT_8K = 13;
  localparam int unsigned PG_SHIFT_64K = 16;

  typedef enum logic [3:0] {
    RI_TAGTGT = 4'd0,
    RI_PCTX   = 4'd1,
    RI_SCTX   = 4'd2,
    RI_FSTAT  = 4'd3,
    RI_FADDR  = 4'd4,
    RI_TSBCFG = 4'd5,
    RI_TAGACC = 4'd6,
    RI_VWATCH = 4'd7,
    RI_PWATCH = 4'd8
  } reg_idx_e;

  function automatic logic [XLEN-1:0] tag_target(input logic [XLEN-1:0] ta);
    logic [XLEN-1:0] ctx_part;
    ctx_part = {{(XLEN-13){1'b0}}, ta[12:0]} << 48;
    return ctx_part | (ta >> 22);
  endfunction
endpackage

// File: rtl/mmu_tsb_ptr.sv
module mmu_tsb_ptr #(
  parameter int unsigned PAGE_SHIFT = 13,
  parameter bit          UPPER_HALF = 1'b0
) (
  input  logic [63:0] tsb_cfg,
  input  logic [63:0] tag_acc,
  output logic [63:0] ptr
);
  logic       split;
  logic [5:0] half_pos;
  logic [5:0] align_sh;
  logic [63:0] base, align_mask, vpn, ent_mask, offs, half;

  always_comb begin
    split      = tsb_cfg[12];
    half_pos   = 6'd13 + {2'b00, tsb_cfg[3:0]};
    align_sh   = half_pos + {5'b0, split};
    base       = {tsb_cfg[63:13], 13'b0};
    align_mask = ~((64'd1 << align_sh) - 64'd1);
    vpn        = tag_acc >> PAGE_SHIFT;
    ent_mask   = (64'd512 << tsb_cfg[3:0]) - 64'd1;
    offs       = (vpn & ent_mask) << 4;
    half       = (split && UPPER_HALF) ? (64'd1 << half_pos) : 64'd0;
    ptr        = (base & align_mask) | half | offs;
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs #(
  parameter bit          DATA_SIDE = 1'b1,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [63:0]      sw_wdata,
  input  logic             flt_valid,
  input  logic [63:0]      flt_status,
  input  logic [63:0]      flt_addr,
  output logic [63:0]      sfsr,
  output logic [63:0]      sfar
);
  import mmu_creg_pkg::*;

  logic sw_fstat;
  assign sw_fstat = sw_we && (sw_idx == IDX_W'(RI_FSTAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      sfsr <= '0;
      sfar <= '0;
    end else if (flt_valid) begin
      sfsr <= flt_status;
      sfar <= flt_addr;
    end else if (sw_fstat) begin
      if (!sw_wdata[0]) begin
        sfsr <= '0;
        if (DATA_SIDE) sfar <= '0;
      end else begin
        sfsr <= sw_wdata;
      end
    end
  end

  assert_faddr_ro_R3: assert property (@(posedge clk) disable iff (rst)
    (sw_we && sw_idx == IDX_W'(RI_FADDR) && !flt_valid) |=> $stable(sfar));

  assert_fstat_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (sw_fstat && !sw_wdata[0] && !flt_valid) |=> (sfsr == 64'd0));

  assert_fault_prio_R10: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> (sfsr == $past(flt_status) && sfar == $past(flt_addr)));
endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile #(
  parameter bit          DATA_SIDE = 1'b1,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CTX_W     = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [63:0]      req_wdata,
  output logic             rsp_valid,
  output logic [63:0]      rsp_rdata,
  input  logic             flt_valid,
  input  logic [63:0]      flt_status,
  input  logic [63:0]      flt_addr,
  input  logic             miss_valid,
  input  logic [63:0]      miss_tag,
  output logic [63:0]      tsb_ptr_8k,
  output logic [63:0]      tsb_ptr_64k,
  output logic [CTX_W-1:0] prim_ctx
);
  import mmu_creg_pkg::*;

  localparam int unsigned NPTR = 2;

  logic        sw_we, sw_re;
  logic [63:0] pctx_q, sctx_q, vwatch_q, pwatch_q;
  logic [63:0] tsb_q, tagacc_q, sfsr_w, sfar_w;
  logic [63:0] rd_mux;
  logic [63:0] ptr_c [NPTR];
  logic [63:0] ptr_q [NPTR];

  assign sw_we = req_valid && req_write;
  assign sw_re = req_valid && !req_write;

  // Registers present on both sides
  always_ff @(posedge clk) begin
    if (rst) begin
      tsb_q    <= '0;
      tagacc_q <= '0;
    end else begin
      if (sw_we && req_idx == IDX_W'(RI_TSBCFG)) tsb_q <= req_wdata;
      if (miss_valid)                             tagacc_q <= miss_tag;
      else if (sw_we && req_idx == IDX_W'(RI_TAGACC)) tagacc_q <= req_wdata;
    end
  end

  // Context and watchpoint registers exist only on the data side
  generate
    if (DATA_SIDE) begin : g_dside
      always_ff @(posedge clk) begin
        if (rst) begin
          pctx_q   <= '0;
          sctx_q   <= '0;
          vwatch_q <= '0;
          pwatch_q <= '0;
        end else if (sw_we) begin
          if (req_idx == IDX_W'(RI_PCTX))   pctx_q   <= req_wdata;
          if (req_idx == IDX_W'(RI_SCTX))   sctx_q   <= req_wdata;
          if (req_idx == IDX_W'(RI_VWATCH)) vwatch_q <= req_wdata;
          if (req_idx == IDX_W'(RI_PWATCH)) pwatch_q <= req_wdata;
        end
      end
    end else begin : g_iside
      assign pctx_q   = '0;
      assign sctx_q   = '0;
      assign vwatch_q = '0;
      assign pwatch_q = '0;
    end
  endgenerate

  mmu_fault_regs #(.DATA_SIDE(DATA_SIDE), .IDX_W(IDX_W)) u_fault (
    .clk        (clk),
    .rst        (rst),
    .sw_we      (sw_we),
    .sw_idx     (req_idx),
    .sw_wdata   (req_wdata),
    .flt_valid  (flt_valid),
    .flt_status (flt_status),
    .flt_addr   (flt_addr),
    .sfsr       (sfsr_w),
    .sfar       (sfar_w)
  );

  // One pointer generator per page size
  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      mmu_tsb_ptr #(
        .PAGE_SHIFT ((g == 0) ? PG_SHIFT_8K : PG_SHIFT_64K),
        .UPPER_HALF (g != 0)
      ) u_ptr (
        .tsb_cfg (tsb_q),
        .tag_acc (tagacc_q),
        .ptr     (ptr_c[g])
      );
      always_ff @(posedge clk) begin
        if (rst) ptr_q[g] <= '0;
        else     ptr_q[g] <= ptr_c[g];
      end
    end
  endgenerate

  assign tsb_ptr_8k  = ptr_q[0];
  assign tsb_ptr_64k = ptr_q[1];
  assign prim_ctx    = pctx_q[CTX_W-1:0];

  always_comb begin
    case (req_idx)
      IDX_W'(RI_TAGTGT): rd_mux = tag_target(tagacc_q);
      IDX_W'(RI_PCTX):   rd_mux = pctx_q;
      IDX_W'(RI_SCTX):   rd_mux = sctx_q;
      IDX_W'(RI_FSTAT):  rd_mux = sfsr_w;
      IDX_W'(RI_FADDR):  rd_mux = sfar_w;
      IDX_W'(RI_TSBCFG): rd_mux = tsb_q;
      IDX_W'(RI_TAGACC): rd_mux = tagacc_q;
      IDX_W'(RI_VWATCH): rd_mux = vwatch_q;
      IDX_W'(RI_PWATCH): rd_mux = pwatch_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sw_re;
      if (sw_re) rsp_rdata <= rd_mux;
    end
  end

  assert_rsp_on_read_R12: assert property (@(posedge clk) disable iff (rst)
    sw_re |=> rsp_valid);

  assert_no_rsp_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !sw_re |=> !rsp_valid);

  assert_miss_prio_R11: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> (tagacc_q == $past(miss_tag)));

  assert_iside_ctx_R5: assert property (@(posedge clk) disable iff (rst)
    (!DATA_SIDE && sw_we && req_idx == IDX_W'(RI_PCTX)) |=> $stable(prim_ctx));
endmodule

// File: tb/mmu_ctl_regfile_tb_top.sv
module mmu_ctl_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic        flt_valid = 1'b0, miss_valid = 1'b0;
  logic [63:0] flt_status = '0, flt_addr = '0, miss_tag = '0;

  logic        d_rv, i_rv;
  logic [63:0] d_rd, i_rd, d_p8, d_p64, i_p8, i_p64;
  logic [12:0] d_ctx, i_ctx;

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] q_d[$], q_i[$];
  string       q_dt[$], q_it[$];

  always #4 clk = ~clk;

  mmu_ctl_regfile #(.DATA_SIDE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(d_rv), .rsp_rdata(d_rd),
    .flt_valid(flt_valid), .flt_status(flt_status), .flt_addr(flt_addr),
    .miss_valid(miss_valid), .miss_tag(miss_tag),
    .tsb_ptr_8k(d_p8), .tsb_ptr_64k(d_p64), .prim_ctx(d_ctx));

  mmu_ctl_regfile #(.DATA_SIDE(1'b0)) dut_ins_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(i_rv), .rsp_rdata(i_rd),
    .flt_valid(flt_valid), .flt_status(flt_status), .flt_addr(flt_addr),
    .miss_valid(miss_valid), .miss_tag(miss_tag),
    .tsb_ptr_8k(i_p8), .tsb_ptr_64k(i_p64), .prim_ctx(i_ctx));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (!rst) begin
      if (d_rv) begin
        if (q_d.size() == 0) check("R12 unexpected data-side response", 64'd1, 64'd0);
        else check(q_dt.pop_front(), d_rd, q_d.pop_front());
      end
      if (i_rv) begin
        if (q_i.size() == 0) check("R12 unexpected instr-side response", 64'd1, 64'd0);
        else check(q_it.pop_front(), i_rd, q_i.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [63:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_idx = idx; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [63:0] exp_d,
                    input logic [63:0] exp_i, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_idx = idx;
    q_d.push_back(exp_d); q_dt.push_back({tag, " dside"});
    q_i.push_back(exp_i); q_it.push_back({tag, " iside"});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] exp_tt(input logic [63:0] ta);
    return ((ta & 64'h1FFF) * (64'd1 << 48)) | (ta >> 22);
  endfunction

  function automatic logic [63:0] exp_ptr(input logic [63:0] cfg, input logic [63:0] ta,
                                          input bit big);
    logic [63:0] base, align, ents, idx;
    int n;
    bit sp;
    n = int'(cfg[3:0]);
    sp = cfg[12];
    base = cfg & ~64'h1FFF;
    align = 64'd1 << (13 + n + (sp ? 1 : 0));
    base = base - (base % align);
    ents = 64'd512 << n;
    idx = (big ? (ta >> 16) : (ta >> 13)) % ents;
    return base + idx * 16 + ((sp && big) ? (64'd1 << (13 + n)) : 64'd0);
  endfunction

  localparam logic [63:0] TA   = 64'hDEAD_BEEF_CAFE_1357;
  localparam logic [63:0] TSBA = 64'h0000_00AB_CDEF_E002;
  localparam logic [63:0] TSBB = 64'h0000_0123_4567_9001;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {63'd0, d_rv}, 64'd0);
    check("R1 ptr8k", d_p8, 64'd0);
    check("R1 ptr64k", i_p64, 64'd0);
    check("R1 prim_ctx", {51'd0, d_ctx}, 64'd0);
    rd(4'd3, 64'd0, 64'd0, "R1 fstat reset");
    rd(4'd6, 64'd0, 64'd0, "R1 tagacc reset");

    // R6 / R5 contexts and watchpoints
    wr(4'd1, 64'hFFFF_0000_0000_ABCD);
    wr(4'd2, 64'h0000_0000_0000_1111);
    wr(4'd7, 64'h7777_0000_0000_0007);
    wr(4'd8, 64'h8888_0000_0000_0008);
    check("R6 prim_ctx low bits", {51'd0, d_ctx}, 64'h0BCD);
    check("R5 iside prim_ctx", {51'd0, i_ctx}, 64'd0);
    rd(4'd1, 64'hFFFF_0000_0000_ABCD, 64'd0, "R6 R5 pctx");
    rd(4'd2, 64'h1111, 64'd0, "R6 R5 sctx");
    rd(4'd7, 64'h7777_0000_0000_0007, 64'd0, "R6 R5 vwatch");
    rd(4'd8, 64'h8888_0000_0000_0008, 64'd0, "R6 R5 pwatch");

    // R2 tag target, R3 read-only
    wr(4'd6, TA);
    rd(4'd6, TA, TA, "R6 tagacc");
    rd(4'd0, exp_tt(TA), exp_tt(TA), "R2 tag target");
    wr(4'd0, 64'h1234_5678_0000_0000);
    rd(4'd0, exp_tt(TA), exp_tt(TA), "R3 tag target write ignored");
    wr(4'd4, 64'hBAD0_BAD0);
    rd(4'd4, 64'd0, 64'd0, "R3 faddr write ignored");

    // R10 fault update and priority
    @(negedge clk);
    flt_valid = 1'b1; flt_status = 64'h8D; flt_addr = 64'h1234;
    @(negedge clk);
    flt_valid = 1'b0;
    rd(4'd3, 64'h8D, 64'h8D, "R10 fault status");
    rd(4'd4, 64'h1234, 64'h1234, "R10 fault addr");
    @(negedge clk);
    flt_valid = 1'b1; flt_status = 64'h9; flt_addr = 64'h77;
    req_valid = 1'b1; req_write = 1'b1; req_idx = 4'd3; req_wdata = 64'h5;
    @(negedge clk);
    flt_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rd(4'd3, 64'h9, 64'h9, "R10 fault beats sw write");
    rd(4'd4, 64'h77, 64'h77, "R10 fault addr priority");

    // R4 fault status clear
    wr(4'd3, 64'h2);
    rd(4'd3, 64'd0, 64'd0, "R4 fstat cleared");
    rd(4'd4, 64'd0, 64'h77, "R4 faddr cleared on data side only");
    wr(4'd3, 64'h41);
    rd(4'd3, 64'h41, 64'h41, "R4 fstat stored");

    // R7 unmapped registers
    wr(4'd9, 64'hFFFF);
    wr(4'd15, 64'hEEEE);
    rd(4'd9, 64'd0, 64'd0, "R7 idx9");
    rd(4'd15, 64'd0, 64'd0, "R7 idx15");

    // R8 / R13 non-split pointers
    wr(4'd5, TSBA);
    @(negedge clk);
    check("R8 R13 dside ptr8k", d_p8, exp_ptr(TSBA, TA, 1'b0));
    check("R8 R13 dside ptr64k", d_p64, exp_ptr(TSBA, TA, 1'b1));
    check("R8 iside ptr8k", i_p8, exp_ptr(TSBA, TA, 1'b0));
    rd(4'd5, TSBA, TSBA, "R6 tsb cfg");

    // R9 split pointers
    wr(4'd5, TSBB);
    @(negedge clk);
    check("R9 ptr8k split", d_p8, exp_ptr(TSBB, TA, 1'b0));
    check("R9 ptr64k split", d_p64, exp_ptr(TSBB, TA, 1'b1));
    check("R9 iside ptr64k split", i_p64, exp_ptr(TSBB, TA, 1'b1));

    // R11 miss priority
    @(negedge clk);
    miss_valid = 1'b1; miss_tag = 64'h0000_4000_0012_0005;
    req_valid = 1'b1; req_write = 1'b1; req_idx = 4'd6; req_wdata = 64'hAAAA;
    @(negedge clk);
    miss_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rd(4'd6, 64'h0000_4000_0012_0005, 64'h0000_4000_0012_0005, "R11 miss beats sw write");
    check("R13 ptr after miss", d_p8, exp_ptr(TSBB, 64'h0000_4000_0012_0005, 1'b0));

    repeat (3) @(negedge clk);
    check("R12 all reads answered", 64'(q_d.size() + q_i.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule